// File: doc/BRIEF.md
# Compare Unit with Event Trigger

This block compares the count of one of two 16-bit timers against a 16-bit compare value that software writes. A compare event happens on the first cycle in which the selected count equals the compare value. What the event does depends on a 4-bit mode field.

Two mode codes drive or clear the compare output pin. A third code only sets a sticky interrupt flag. A fourth code, the trigger mode, also raises a one-cycle reset strobe toward the selected timer, so the compare value acts as that timer's period. When the converter enable input is high, the trigger mode also raises a one-cycle converter-start strobe.

A build parameter turns off trigger support. On such instances the trigger code behaves exactly like the interrupt-only code. The strobes are combinational from the match, so a timer that honours the reset strobe at its next clock edge wraps from the compare value straight to zero.

Top module: `cmp_trigger_unit`

## Requirements
- R1: A compare event happens only in the first cycle in which the selected count equals the compare value. While the count stays equal, no further event is raised.
- R2: In mode 4'b1011 on an instance with trigger support, the event drives a one-cycle reset strobe in the same cycle as the match. The strobe goes only to the timer chosen by the timer-select input (0 selects timer 0, 1 selects timer 1).
- R3: The converter-start strobe pulses with the trigger event only when the converter enable input is high.
- R4: Mode 4'b1010 raises no reset or converter strobe, but it still sets the interrupt flag on a match.
- R5: On an instance built without trigger support, mode 4'b1011 raises no strobes and sets the interrupt flag just as 4'b1010 does.
- R6: Every event in any mode 4'b10xx sets the interrupt flag one cycle later. The flag stays set until the clear input is high. A set and a clear in the same cycle leave the flag set.
- R7: A compare value written in one cycle is used for comparison from the next cycle on.
- R8: The compare pin is driven high by an event in mode 4'b1000 and low by an event in mode 4'b1001. Modes 4'b1010 and 4'b1011 leave it unchanged. Mode 4'b0000 forces it low.
- R9: Modes outside 4'b10xx produce no event: the interrupt flag is not set and no strobe pulses.
- R10: With a free-running timer that honours its reset strobe, trigger mode with compare value C gives one reset strobe every C+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 4 | Compare mode code |
| cmp_wr_en | input | 1 | Write strobe for the compare value |
| cmp_wr_data | input | 16 | New compare value |
| tmr_sel | input | 1 | Selects the timer to compare against and to reset |
| tmr0_cnt | input | 16 | Timer 0 count |
| tmr1_cnt | input | 16 | Timer 1 count |
| conv_en | input | 1 | Converter enabled |
| irq_clr | input | 1 | Clears the interrupt flag |
| tmr0_rst | output | 1 | Reset strobe for timer 0 |
| tmr1_rst | output | 1 | Reset strobe for timer 1 |
| conv_start | output | 1 | Converter start strobe |
| cmp_irq | output | 1 | Sticky compare interrupt flag |
| cmp_pin | output | 1 | Compare output pin |

## Verification
The bench holds a timer on the compare value for several cycles. A level-sensitive design would keep strobing there, while a correct one pulses once. It switches the timer select, so a strobe routed to the wrong timer shows up. It also runs the trigger code on an instance without trigger support, where an unguarded decode would still reset the timer. It writes a new compare value that equals the held count and checks the cycle before and after the write, which exposes a bypass or an extra pipeline stage. It also clears the flag in the same cycle as a new event, and it measures the wrap period with a live counter, where a registered strobe would stretch the period by one.

// File: rtl/cmp_trigger_unit.sv
module cmp_trigger_unit #(
  parameter int TW       = 16,
  parameter bit HAS_TRIG = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode,
  input  logic          cmp_wr_en,
  input  logic [TW-1:0] cmp_wr_data,
  input  logic          tmr_sel,
  input  logic [TW-1:0] tmr0_cnt,
  input  logic [TW-1:0] tmr1_cnt,
  input  logic          conv_en,
  input  logic          irq_clr,
  output logic          tmr0_rst,
  output logic          tmr1_rst,
  output logic          conv_start,
  output logic          cmp_irq,
  output logic          cmp_pin
);
  localparam logic [3:0] M_OFF  = 4'b0000;
  localparam logic [3:0] M_SET  = 4'b1000;
  localparam logic [3:0] M_CLR  = 4'b1001;
  localparam logic [3:0] M_TRIG = 4'b1011;

  logic [TW-1:0] cmp_q;
  logic          match_q;
  logic          match_now;
  logic          hit;
  logic          trig;

  assign match_now = ((tmr_sel ? tmr1_cnt : tmr0_cnt) == cmp_q);
  assign hit       = (mode[3:2] == 2'b10) && match_now && !match_q;
  assign trig      = HAS_TRIG && (mode == M_TRIG) && hit;

  assign tmr0_rst   = trig && !tmr_sel;
  assign tmr1_rst   = trig &&  tmr_sel;
  assign conv_start = trig && conv_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q   <= '0;
      match_q <= 1'b0;
      cmp_irq <= 1'b0;
      cmp_pin <= 1'b0;
    end else begin
      if (cmp_wr_en) cmp_q <= cmp_wr_data;
      match_q <= match_now;
      if (hit)          cmp_irq <= 1'b1;
      else if (irq_clr) cmp_irq <= 1'b0;
      if (mode == M_OFF)                  cmp_pin <= 1'b0;
      else if (hit && mode == M_SET)      cmp_pin <= 1'b1;
      else if (hit && mode == M_CLR)      cmp_pin <= 1'b0;
    end
  end

  a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr0_rst && !tmr_sel) |=> !tmr0_rst);
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tmr0_rst, tmr1_rst}));
  a_r3_conv_needs_en: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start |-> (conv_en && (tmr0_rst || tmr1_rst)));
  a_r6_irq_set: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr0_rst || tmr1_rst) |=> cmp_irq);
  a_r6_irq_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_irq && !irq_clr) |=> cmp_irq);
  a_r8_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_OFF) |=> !cmp_pin);

  generate
    if (!HAS_TRIG) begin : g_no_trig
      a_r5_no_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        !(tmr0_rst || tmr1_rst || conv_start));
    end
  endgenerate
endmodule

// File: tb/cmp_trigger_unit_bench.sv
module cmp_trigger_unit_bench;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic [3:0]  mode;
  logic        cmp_wr_en;
  logic [15:0] cmp_wr_data;
  logic        tmr_sel;
  logic [15:0] tmr0_cnt;
  logic [15:0] tmr1_cnt;
  logic        conv_en;
  logic        irq_clr;
  logic        run0;
  logic        tmr0_rst, tmr1_rst, conv_start, cmp_irq, cmp_pin;
  logic        n_rst0, n_rst1, n_conv, n_irq, n_pin;
  int          total = 0;
  int          bad   = 0;

  cmp_trigger_unit u_cmp_trigger_unit (
    .clk, .rst_n, .mode, .cmp_wr_en, .cmp_wr_data, .tmr_sel, .tmr0_cnt,
    .tmr1_cnt, .conv_en, .irq_clr, .tmr0_rst, .tmr1_rst, .conv_start,
    .cmp_irq, .cmp_pin);

  cmp_trigger_unit #(.TW(16), .HAS_TRIG(1'b0)) u_cmp_trigger_unit_nt (
    .clk, .rst_n, .mode, .cmp_wr_en, .cmp_wr_data, .tmr_sel, .tmr0_cnt,
    .tmr1_cnt, .conv_en, .irq_clr, .tmr0_rst(n_rst0), .tmr1_rst(n_rst1),
    .conv_start(n_conv), .cmp_irq(n_irq), .cmp_pin(n_pin));

  always @(posedge clk)
    if (run0) tmr0_cnt <= tmr0_rst ? 16'd0 : tmr0_cnt + 16'd1;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk); #1;
  endtask

  task automatic write_cmp(input logic [15:0] v);
    @(negedge clk); cmp_wr_en = 1'b1; cmp_wr_data = v;
    @(negedge clk); cmp_wr_en = 1'b0; #1;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0; #1;
  endtask

  task automatic t_reset();
    chk("R6 reset irq", cmp_irq, 0);
    chk("R8 reset pin", cmp_pin, 0);
    chk("R2 reset strobe", tmr0_rst | tmr1_rst | conv_start, 0);
  endtask

  task automatic t_trigger();
    mode = 4'b1011; tmr_sel = 1'b0; conv_en = 1'b0;
    write_cmp(16'd5);
    tmr0_cnt = 16'd4; step();
    chk("R2 no match", tmr0_rst, 0);
    @(negedge clk); tmr0_cnt = 16'd5; #1;
    chk("R2 rst0 on match", tmr0_rst, 1);
    chk("R2 rst1 idle", tmr1_rst, 0);
    chk("R3 conv gated", conv_start, 0);
    chk("R5 no-trig rst0", n_rst0, 0);
    step();
    chk("R1 held match no pulse", tmr0_rst, 0);
    chk("R6 irq set", cmp_irq, 1);
    chk("R5 no-trig irq", n_irq, 1);
    step();
    chk("R1 still no pulse", tmr0_rst, 0);
    conv_en = 1'b1;
    @(negedge clk); tmr0_cnt = 16'd6; #1;
    @(negedge clk); tmr0_cnt = 16'd5; #1;
    chk("R3 conv start", conv_start, 1);
    chk("R5 no-trig conv", n_conv, 0);
    tmr_sel = 1'b1; tmr0_cnt = 16'd0; tmr1_cnt = 16'd5; #1;
    chk("R2 rst1 selected", tmr1_rst, 1);
    chk("R2 rst0 not selected", tmr0_rst, 0);
    step();
    tmr_sel = 1'b0; conv_en = 1'b0;
  endtask

  task automatic t_irq_only();
    clear_irq();
    chk("R6 irq cleared", cmp_irq, 0);
    mode = 4'b1010;
    @(negedge clk); tmr0_cnt = 16'd1; #1;
    @(negedge clk); tmr0_cnt = 16'd5; conv_en = 1'b1; #1;
    chk("R4 no rst", tmr0_rst | tmr1_rst, 0);
    chk("R4 no conv", conv_start, 0);
    step();
    chk("R4 irq set", cmp_irq, 1);
    conv_en = 1'b0;
    @(negedge clk); tmr0_cnt = 16'd1; #1;
    @(negedge clk); tmr0_cnt = 16'd5; irq_clr = 1'b1; #1;
    @(negedge clk); irq_clr = 1'b0; #1;
    chk("R6 set beats clear", cmp_irq, 1);
  endtask

  task automatic t_write_timing();
    mode = 4'b1011; tmr0_cnt = 16'd9;
    step();
    clear_irq();
    @(negedge clk); cmp_wr_en = 1'b1; cmp_wr_data = 16'd9; #1;
    chk("R7 old value still used", tmr0_rst, 0);
    @(negedge clk); cmp_wr_en = 1'b0; #1;
    chk("R7 new value used", tmr0_rst, 1);
    step();
  endtask

  task automatic t_pin();
    mode = 4'b1000; tmr0_cnt = 16'd0; step();
    @(negedge clk); tmr0_cnt = 16'd9; #1;
    step();
    chk("R8 set mode", cmp_pin, 1);
    mode = 4'b1010; tmr0_cnt = 16'd0; step();
    @(negedge clk); tmr0_cnt = 16'd9; #1;
    step();
    chk("R8 irq mode holds", cmp_pin, 1);
    mode = 4'b1001; tmr0_cnt = 16'd0; step();
    @(negedge clk); tmr0_cnt = 16'd9; #1;
    step();
    chk("R8 clear mode", cmp_pin, 0);
    mode = 4'b1000; tmr0_cnt = 16'd0; step();
    @(negedge clk); tmr0_cnt = 16'd9; #1;
    step();
    mode = 4'b0000; step();
    chk("R8 off forces low", cmp_pin, 0);
  endtask

  task automatic t_other_modes();
    clear_irq();
    mode = 4'b0100; tmr0_cnt = 16'd0; step();
    @(negedge clk); tmr0_cnt = 16'd9; #1;
    chk("R9 no strobe", tmr0_rst, 0);
    step();
    chk("R9 no irq", cmp_irq, 0);
  endtask

  task automatic t_period();
    int first, second;
    first = -1; second = -1;
    mode = 4'b1011; tmr_sel = 1'b0;
    write_cmp(16'd3);
    @(negedge clk); tmr0_cnt = 16'd0; run0 = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); #1;
      if (tmr0_rst) begin
        if (first < 0) first = i;
        else if (second < 0) second = i;
      end
    end
    run0 = 1'b0;
    chk("R10 period", second - first, 4);
  endtask

  initial begin
    rst_n = 1'b0; mode = 4'b0000; cmp_wr_en = 1'b0; cmp_wr_data = '0;
    tmr_sel = 1'b0; tmr0_cnt = 16'd1; tmr1_cnt = 16'd1; conv_en = 1'b0;
    irq_clr = 1'b0; run0 = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1; #1;
    t_reset();
    t_trigger();
    t_irq_only();
    t_write_timing();
    t_pin();
    t_other_modes();
    t_period();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule